// File: doc/BRIEF.md
# Packed Byte Staging Buffer

This block sits between a 16-bit register data port and a byte-serial engine. A single packed store of four byte slots is shared by both directions. Software-side writes push two bytes at once for transmission, and the engine takes them one at a time. The engine deposits received bytes one at a time, and software-side reads drain them two at a time. A byte-order input sets how a 16-bit word maps onto the two bytes it carries.

Separate transmit and receive levels track how many slots each direction uses. Four sticky condition flags are presented to the surrounding status logic, which clears them through a per-flag acknowledge vector. At most one buffer operation takes effect per cycle. When several strobes are raised together, a fixed priority picks the one that acts.

Top module: `packed_byte_buffer`

## Requirements
- R1: After a synchronous active-low reset, both levels are 0, all four flags are low, and both tx_byte and rd_data read 0.
- R2: A write with tx_level of 2 or less shifts the store up by 16 bits, places the new word in bits 15:0, and adds 2 to tx_level. Byte k occupies bits 8k+7:8k. With byte_swap=0, wr_data[7:0] goes to byte 1 and wr_data[15:8] to byte 0. With byte_swap=1, wr_data[15:8] goes to byte 1 and wr_data[7:0] to byte 0.
- R3: A write while tx_level is above 2 is ignored: the store, both levels and all flags are unchanged.
- R4: An accepted write clears tx_udf. It also clears tx_rdy when the resulting tx_level is above 2.
- R5: While tx_level is nonzero, tx_byte shows byte (tx_level-1). A pop decrements tx_level and sets tx_rdy.
- R6: While tx_level is 0, tx_byte is 0. A pop then leaves tx_level at 0 and sets both tx_udf and tx_rdy.
- R7: A push with rx_level below 4 stores rx_byte in byte rx_level and increments rx_level.
- R8: A push with rx_level equal to 4 drops the byte, leaves the store unchanged, and sets rx_ovr.
- R9: rd_data is {byte 1, byte 0} when byte_swap=0 and {byte 0, byte 1} when byte_swap=1.
- R10: A read always clears rx_ovr. The effect on rx_level depends on its value:
  - rx_level 1: sets rx_single and rx_level becomes 0.
  - rx_level 2: rx_level becomes 0.
  - rx_level above 2: shifts the store down by 16 bits and subtracts 2 from rx_level.
  - rx_level 0: the level is unchanged.
- R11: A read that takes rx_level from nonzero to zero clears the whole store to 0.
- R12: When several strobes are raised in one cycle, only the highest-priority one acts. The order is write, then read, then pop, then push.
- R13: Each bit of flag_ack clears one flag: bit 0 clears rx_ovr, bit 1 clears tx_udf, bit 2 clears tx_rdy, bit 3 clears rx_single. If an operation sets a flag in the same cycle that its acknowledge clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_swap | input | 1 | Byte-order select for word writes and reads |
| wr_en | input | 1 | Data word write strobe |
| wr_data | input | 16 | Data word to queue for transmit |
| rd_en | input | 1 | Data word read strobe |
| rd_data | output | 16 | Lower two bytes of the store, ordered by byte_swap |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_byte | output | 8 | Transmit byte offered to the engine |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| flag_ack | input | 4 | Per-flag clear from status logic |
| tx_level | output | 3 | Queued transmit bytes |
| rx_level | output | 3 | Held receive bytes |
| rx_ovr | output | 1 | Receive overrun flag |
| tx_udf | output | 1 | Transmit underflow flag |
| tx_rdy | output | 1 | Transmit ready flag |
| rx_single | output | 1 | Single-byte read flag |

## Verification
The transmit path is swept over both byte orders with one, two and three writes. Each run then pops past empty, so the sweep separates correct slot selection from reversed order and exposes the full-queue write rejection. The receive path is swept with zero to five pushes followed by repeated reads. This distinguishes the odd-count single-byte case, the shift-down case, the overrun drop and the clear-on-empty store.

All fifteen combinations of simultaneous strobes are applied on a preloaded store to tell the priority order apart. The acknowledge sweep clears each flag alone and then collides an acknowledge with a setting event.

// File: rtl/pkbuf_pkg.sv
// Shared types for the packed byte staging buffer.
// Assumes one buffer operation per cycle, chosen by priority in the top module.
package pkbuf_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_POP   = 3'd3,
        OP_PUSH  = 3'd4
    } op_e;

    localparam int FLG_OVR  = 0;
    localparam int FLG_UDF  = 1;
    localparam int FLG_RDY  = 2;
    localparam int FLG_SGL  = 3;
    localparam int FLAG_N   = 4;
endpackage

// File: rtl/pkb_tx_ctrl.sv
// Transmit level and transmit-side flags.
// Assumes op already carries the single winning operation of the cycle.
module pkb_tx_ctrl import pkbuf_pkg::*; #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             ack_udf,
    input  logic             ack_rdy,
    output logic [CNT_W-1:0] level,
    output logic             wr_take,
    output logic             udf,
    output logic             rdy
);
    localparam logic [CNT_W-1:0] WR_MAX = CNT_W'(SLOTS - 2);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO    = CNT_W'(2);

    logic [CNT_W-1:0] level_n;
    logic             udf_n;
    logic             rdy_n;

    assign wr_take = (op == OP_WRITE) && (level <= WR_MAX);

    // Next level and flags: acknowledges first, then the operation.
    always_comb begin
        level_n = level;
        udf_n   = udf & ~ack_udf;
        rdy_n   = rdy & ~ack_rdy;
        case (op)
            OP_WRITE: begin
                if (wr_take) begin
                    level_n = level + TWO;
                    udf_n   = 1'b0;
                    if (level_n > TWO) rdy_n = 1'b0;
                end
            end
            OP_POP: begin
                rdy_n = 1'b1;
                if (level == '0) udf_n = 1'b1;
                else             level_n = level - ONE;
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            udf   <= 1'b0;
            rdy   <= 1'b0;
        end else begin
            level <= level_n;
            udf   <= udf_n;
            rdy   <= rdy_n;
        end
    end
endmodule

// File: rtl/pkb_rx_ctrl.sv
// Receive level and receive-side flags; tells the store when to shift or clear.
// Assumes op already carries the single winning operation of the cycle.
module pkb_rx_ctrl import pkbuf_pkg::*; #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic             ack_ovr,
    input  logic             ack_sgl,
    output logic [CNT_W-1:0] level,
    output logic             push_take,
    output logic             rd_empty,
    output logic             rd_shift,
    output logic             ovr,
    output logic             sgl
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

    logic [CNT_W-1:0] level_n;
    logic             ovr_n;
    logic             sgl_n;

    assign push_take = (op == OP_PUSH) && (level != FULL);
    assign rd_empty  = (op == OP_READ) && (level == ONE || level == TWO);
    assign rd_shift  = (op == OP_READ) && (level > TWO);

    // Next level and flags: acknowledges first, then the operation.
    always_comb begin
        level_n = level;
        ovr_n   = ovr & ~ack_ovr;
        sgl_n   = sgl & ~ack_sgl;
        case (op)
            OP_READ: begin
                ovr_n = 1'b0;
                if (level == ONE) begin
                    sgl_n   = 1'b1;
                    level_n = '0;
                end else if (level >= TWO) begin
                    level_n = level - TWO;
                end
            end
            OP_PUSH: begin
                if (push_take) level_n = level + ONE;
                else           ovr_n   = 1'b1;
            end
            default: ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            ovr   <= 1'b0;
            sgl   <= 1'b0;
        end else begin
            level <= level_n;
            ovr   <= ovr_n;
            sgl   <= sgl_n;
        end
    end
endmodule

// File: rtl/pkb_store.sv
// Packed byte store shared by both directions, with byte selection and ordering.
// Assumes at most one of wr_take, rd_empty, rd_shift, push_take is high.
module pkb_store #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                swap,
    input  logic                wr_take,
    input  logic [2*BYTE_W-1:0] wr_data,
    input  logic                push_take,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic [CNT_W-1:0]    rx_level,
    input  logic                rd_empty,
    input  logic                rd_shift,
    input  logic [CNT_W-1:0]    tx_level,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic [2*BYTE_W-1:0] rd_data
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam int BUF_W  = SLOTS * BYTE_W;

    logic [BUF_W-1:0]  data_q;
    logic [BUF_W-1:0]  data_n;
    logic [WORD_W-1:0] wr_word;
    logic [BYTE_W-1:0] b0;
    logic [BYTE_W-1:0] b1;

    // Word-to-byte mapping for writes, selected by byte order.
    assign wr_word = swap ? wr_data : {wr_data[BYTE_W-1:0], wr_data[WORD_W-1:BYTE_W]};

    // Bytes-to-word mapping for reads.
    assign b0      = data_q[BYTE_W-1:0];
    assign b1      = data_q[WORD_W-1:BYTE_W];
    assign rd_data = swap ? {b0, b1} : {b1, b0};

    // Offer the byte at slot (tx_level-1), or zero when nothing is queued.
    always_comb begin
        tx_byte = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (tx_level == CNT_W'(i + 1)) tx_byte = data_q[i*BYTE_W +: BYTE_W];
        end
    end

    // Next store contents for the winning operation.
    always_comb begin
        data_n = data_q;
        if (wr_take) begin
            data_n = {data_q[BUF_W-WORD_W-1:0], wr_word};
        end else if (rd_empty) begin
            data_n = '0;
        end else if (rd_shift) begin
            data_n = data_q >> WORD_W;
        end else if (push_take) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (rx_level == CNT_W'(i)) data_n[i*BYTE_W +: BYTE_W] = rx_byte;
            end
        end
    end

    // Store register.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_n;
    end
endmodule

// File: rtl/packed_byte_buffer.sv
// Top: picks one operation per cycle by priority and joins the level trackers
// with the shared store. Assumes strobes are synchronous to clk.
module packed_byte_buffer import pkbuf_pkg::*; #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_swap,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [FLAG_N-1:0] flag_ack,
    output logic [CNT_W-1:0]  tx_level,
    output logic [CNT_W-1:0]  rx_level,
    output logic              rx_ovr,
    output logic              tx_udf,
    output logic              tx_rdy,
    output logic              rx_single
);
    op_e  op;
    logic wr_take;
    logic push_take;
    logic rd_empty;
    logic rd_shift;

    // Priority select: write, read, pop, push.
    always_comb begin
        op = OP_NONE;
        if (wr_en)        op = OP_WRITE;
        else if (rd_en)   op = OP_READ;
        else if (tx_pop)  op = OP_POP;
        else if (rx_push) op = OP_PUSH;
    end

    pkb_tx_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ack_udf (flag_ack[FLG_UDF]),
        .ack_rdy (flag_ack[FLG_RDY]),
        .level   (tx_level),
        .wr_take (wr_take),
        .udf     (tx_udf),
        .rdy     (tx_rdy)
    );

    pkb_rx_ctrl #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ack_ovr   (flag_ack[FLG_OVR]),
        .ack_sgl   (flag_ack[FLG_SGL]),
        .level     (rx_level),
        .push_take (push_take),
        .rd_empty  (rd_empty),
        .rd_shift  (rd_shift),
        .ovr       (rx_ovr),
        .sgl       (rx_single)
    );

    pkb_store #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (byte_swap),
        .wr_take   (wr_take),
        .wr_data   (wr_data),
        .push_take (push_take),
        .rx_byte   (rx_byte),
        .rx_level  (rx_level),
        .rd_empty  (rd_empty),
        .rd_shift  (rd_shift),
        .tx_level  (tx_level),
        .tx_byte   (tx_byte),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/pkb_checker.sv
// Temporal checks on the buffer's ports, bound to every instance of the top.
module pkb_checker #(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              tx_pop,
    input logic              rx_push,
    input logic [BYTE_W-1:0] tx_byte,
    input logic [CNT_W-1:0]  tx_level,
    input logic [CNT_W-1:0]  rx_level,
    input logic              rx_ovr,
    input logic              tx_udf,
    input logic              tx_rdy,
    input logic              rx_single
);
    localparam logic [CNT_W-1:0] WR_MAX = CNT_W'(SLOTS - 2);
    localparam logic [CNT_W-1:0] FULL   = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO    = CNT_W'(2);

    AST_WR_ADDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && tx_level <= WR_MAX |=> tx_level == $past(tx_level) + TWO && !tx_udf); // R2
    AST_WR_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && tx_level > WR_MAX |=> $stable(tx_level)); // R3
    AST_POP_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop && !wr_en && !rd_en && tx_level == '0 |-> tx_byte == '0); // R6
    AST_POP_EMPTY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop && !wr_en && !rd_en && tx_level == '0 |=> tx_udf && tx_rdy && tx_level == '0); // R6
    AST_PUSH_FULL_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && !wr_en && !rd_en && !tx_pop && rx_level == FULL |=> rx_ovr && rx_level == FULL); // R8
    AST_READ_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en |=> !rx_ovr); // R10
    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && rx_level == ONE |=> rx_single && rx_level == '0); // R10
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rx_level)); // R12
    AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= FULL && rx_level <= FULL); // R2
endmodule

bind packed_byte_buffer pkb_checker #(.SLOTS(SLOTS), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .tx_pop    (tx_pop),
    .rx_push   (rx_push),
    .tx_byte   (tx_byte),
    .tx_level  (tx_level),
    .rx_level  (rx_level),
    .rx_ovr    (rx_ovr),
    .tx_udf    (tx_udf),
    .tx_rdy    (tx_rdy),
    .rx_single (rx_single)
);

// File: tb/packed_byte_buffer_tb.sv
`timescale 1ns/1ps
// Sweeping bench with an arithmetic model of the byte store.
module packed_byte_buffer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_byte;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  flag_ack = '0;
    logic [2:0]  tx_level;
    logic [2:0]  rx_level;
    logic        rx_ovr, tx_udf, tx_rdy, rx_single;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [31:0] mdat;
    int          mtx, mrx;
    bit          movr, mudf, mrdy, msgl;

    always #10 clk = ~clk;

    packed_byte_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .byte_swap(swap),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_pop(tx_pop), .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
        .flag_ack(flag_ack), .tx_level(tx_level), .rx_level(rx_level),
        .rx_ovr(rx_ovr), .tx_udf(tx_udf), .tx_rdy(tx_rdy), .rx_single(rx_single)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        return swap ? {mdat[7:0], mdat[15:8]} : mdat[15:0];
    endfunction

    function automatic logic [7:0] exp_tx();
        if (mtx == 0) return 8'h00;
        return 8'(mdat >> (8 * (mtx - 1)));
    endfunction

    task automatic check_state(input string req);
        chk(req, "tx_level", 32'(tx_level), 32'(mtx));
        chk(req, "rx_level", 32'(rx_level), 32'(mrx));
        chk(req, "flags", {28'h0, rx_single, tx_rdy, tx_udf, rx_ovr}, {28'h0, msgl, mrdy, mudf, movr});
        chk(req, "rd_data", 32'(rd_data), 32'(exp_rd()));
        chk(req, "tx_byte", 32'(tx_byte), 32'(exp_tx()));
    endtask

    task automatic model_apply(input bit w, input bit r, input bit p, input bit u,
                               input logic [15:0] wd, input logic [7:0] rb, input logic [3:0] ack);
        logic [15:0] pk;
        if (ack[0]) movr = 0;
        if (ack[1]) mudf = 0;
        if (ack[2]) mrdy = 0;
        if (ack[3]) msgl = 0;
        if (w) begin
            if (mtx <= 2) begin
                pk   = swap ? wd : {wd[7:0], wd[15:8]};
                mdat = (mdat << 16) | {16'h0, pk};
                mtx  = mtx + 2;
                mudf = 0;
                if (mtx > 2) mrdy = 0;
            end
        end else if (r) begin
            movr = 0;
            if (mrx == 1) begin
                msgl = 1; mrx = 0; mdat = '0;
            end else if (mrx >= 2) begin
                if (mrx > 2) mdat = mdat >> 16;
                else         mdat = '0;
                mrx = mrx - 2;
            end
        end else if (p) begin
            mrdy = 1;
            if (mtx == 0) mudf = 1;
            else          mtx  = mtx - 1;
        end else if (u) begin
            if (mrx == 4) movr = 1;
            else begin
                mdat[8*mrx +: 8] = rb;
                mrx = mrx + 1;
            end
        end
    endtask

    // One cycle of stimulus: drive mid-cycle, check offered outputs, check state after the edge.
    task automatic step(input string req, input bit w, input bit r, input bit p, input bit u,
                        input logic [15:0] wd, input logic [7:0] rb, input logic [3:0] ack);
        @(negedge clk);
        wr_en = w; rd_en = r; tx_pop = p; rx_push = u;
        wr_data = wd; rx_byte = rb; flag_ack = ack;
        #2;
        chk("R5", "tx_byte before edge", 32'(tx_byte), 32'(exp_tx()));
        chk("R9", "rd_data before edge", 32'(rd_data), 32'(exp_rd()));
        model_apply(w, r, p, u, wd, rb, ack);
        @(posedge clk);
        #2;
        wr_en = 0; rd_en = 0; tx_pop = 0; rx_push = 0; flag_ack = '0;
        check_state(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(posedge clk);
        #2;
        mdat = '0; mtx = 0; mrx = 0; movr = 0; mudf = 0; mrdy = 0; msgl = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    // Watchdog
    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        check_state("R1");

        // Transmit sweep: R2 R3 R4 R5 R6
        for (int sw = 0; sw < 2; sw++) begin
            for (int nw = 1; nw <= 3; nw++) begin
                swap = sw[0];
                do_reset();
                for (int k = 0; k < nw; k++)
                    step(nw == 3 && k == 2 ? "R3" : "R2", 1, 0, 0, 0,
                         16'h1234 ^ 16'(k * 16'h0F0F) ^ 16'(sw * 16'h5A00), 8'h00, 4'h0);
                for (int k = 0; k < 6; k++)
                    step(k >= 2 * (nw > 2 ? 2 : nw) ? "R6" : "R5", 0, 0, 1, 0, 16'h0, 8'h00, 4'h0);
                chk("R6", "tx_byte at empty", 32'(tx_byte), 32'h0);
                step("R4", 1, 0, 0, 0, 16'hC3A5, 8'h00, 4'h0);
                step("R4", 1, 0, 0, 0, 16'h9E71, 8'h00, 4'h0);
                step("R3", 1, 0, 0, 0, 16'hFFFF, 8'h00, 4'h0);
            end
        end

        // Receive sweep: R7 R8 R9 R10 R11
        for (int sw = 0; sw < 2; sw++) begin
            for (int np = 0; np <= 5; np++) begin
                swap = sw[0];
                do_reset();
                for (int k = 0; k < np; k++)
                    step(k >= 4 ? "R8" : "R7", 0, 0, 0, 1, 16'h0, 8'(8'h11 * (k + 1) + sw), 4'h0);
                for (int k = 0; k < 3; k++)
                    step("R10", 0, 1, 0, 0, 16'h0, 8'h00, 4'h0);
                chk("R11", "store cleared", 32'(rd_data), 32'h0);
            end
        end

        // Priority sweep: R12
        for (int m = 1; m < 16; m++) begin
            swap = 1'b0;
            do_reset();
            step("R12", 1, 0, 0, 0, 16'hAB12, 8'h00, 4'h0);
            step("R12", 0, 0, 0, 1, 16'h0, 8'h3C, 4'h0);
            step("R12", m[3], m[2], m[1], m[0], 16'h7788, 8'hE4, 4'h0);
        end

        // Acknowledge sweep: R13
        for (int b = 0; b < 4; b++) begin
            swap = 1'b1;
            do_reset();
            step("R13", 0, 0, 0, 1, 16'h0, 8'h5D, 4'h0);
            step("R13", 0, 1, 0, 0, 16'h0, 8'h00, 4'h0);
            for (int k = 0; k < 5; k++)
                step("R13", 0, 0, 0, 1, 16'h0, 8'(8'h20 + k), 4'h0);
            step("R13", 0, 0, 1, 0, 16'h0, 8'h00, 4'h0);
            step("R13", 0, 0, 0, 0, 16'h0, 8'h00, 4'(1 << b));
            step("R13", 0, 0, 1, 0, 16'h0, 8'h00, 4'b0110);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule